// File: doc/BRIEF.md
# Dual-Read Distributed Memory

This block is a small register-file style memory. It has one synchronous write port and two read outputs. A single address bus, the shared port, picks both the word that is written and the word shown on the first read output. A second address bus has no write path. It drives its own output and is independent of the shared port. A design that needs only one port ties off the second address and leaves its output unconnected.

Writes happen on a rising clock edge while the write enable is high. In the default mode both reads are combinational, so the outputs follow their addresses with no clock involved. Setting a parameter adds an output register to each read port. Reads then become synchronous with one cycle of latency. In both modes a read that hits the location being written returns the new word (write-first).

The memory array itself is never cleared. Only the optional output registers respond to reset.

Top module: `dual_read_ram`

## Requirements
- R1: On a rising clock edge with `wrEn` high, `wrData` is stored at `rwAddr`. It can be read back from that location after the edge.
- R2: On a rising clock edge with `wrEn` low, no location changes.
- R3: With `REG_OUT` = 0, `rwData` shows the stored word at `rwAddr` combinationally. A change of address shows up without waiting for a clock edge.
- R4: With `REG_OUT` = 0, `roData` shows the stored word at `roAddr` combinationally, whatever the shared port is doing.
- R5: A write through the shared port to one location leaves `roData` unchanged while `roAddr` points at a different location.
- R6: Write-first: after a write edge, any output whose address equals the written address shows the newly written word. This holds on both ports.
- R7: With `REG_OUT` = 1, each output takes, on the rising edge, the word its address selected in the preceding cycle. If that address is being written on the same edge, the output takes the new `wrData`.
- R8: With `REG_OUT` = 1, both outputs are zero after an edge that sees `rstN` low. Reset never alters the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and output registers act on its rising edge |
| rstN | input | 1 | Active-low reset for the optional output registers only |
| wrEn | input | 1 | Write enable for the shared port |
| rwAddr | input | ADDR_W | Shared write and first-read address |
| wrData | input | DATA_W | Word to store |
| roAddr | input | ADDR_W | Address of the read-only port |
| rwData | output | DATA_W | Word at the shared address |
| roData | output | DATA_W | Word at the read-only address |

## Verification
A write through the shared port and a read through the read-only port can fall in the same cycle. This happens either at two distinct addresses or at one address. The bench sweeps every pairing of write address and read-only address on a 16-word memory. It runs a combinational instance and a registered instance side by side. Before the edge it checks the read-only output against the old contents. After the edge it expects the new word only when the two addresses match, and it expects the other location to stay untouched.

// File: rtl/dual_read_ram_pkg.sv
package dual_read_ram_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;   // commit a word into the array this edge
    logic outLoad;    // output registers sample their next value
    logic outClear;   // output registers are forced to zero
  } ramCtrl_t;

endpackage

// File: rtl/dual_read_ram_ctrl.sv
module dual_read_ram_ctrl
  import dual_read_ram_pkg::*;
(
  input  logic     rstN,
  input  logic     wrEn,
  output ramCtrl_t ctrl
);

  // Reset never gates the array write, so the contents survive reset.
  always_comb begin
    ctrl.wrStrobe = wrEn;
    ctrl.outClear = !rstN;
    ctrl.outLoad  = rstN;
  end

endmodule

// File: rtl/dual_read_ram_datapath.sv
module dual_read_ram_datapath
  import dual_read_ram_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  ramCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] rwAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] roAddr,
  output logic [DATA_W-1:0] rwData,
  output logic [DATA_W-1:0] roData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [DATA_W-1:0] rwComb;
  logic [DATA_W-1:0] roComb;

  // Single-edge write, no reset on the array
  always_ff @(posedge clk) begin
    if (ctrl.wrStrobe) memArray[rwAddr] <= wrData;
  end

  // Combinational reads: both ports see the array directly
  assign rwComb = memArray[rwAddr];
  assign roComb = memArray[roAddr];

  generate
    if (REG_OUT) begin : g_regOut
      logic [DATA_W-1:0] rwQ;
      logic [DATA_W-1:0] roQ;
      logic [DATA_W-1:0] rwNext;
      logic [DATA_W-1:0] roNext;
      logic              roHit;

      // Write-first bypass: a colliding read takes the incoming word
      assign roHit  = ctrl.wrStrobe && (roAddr == rwAddr);
      assign rwNext = ctrl.wrStrobe ? wrData : rwComb;
      assign roNext = roHit ? wrData : roComb;

      always_ff @(posedge clk) begin
        if (ctrl.outClear) begin
          rwQ <= '0;
          roQ <= '0;
        end else if (ctrl.outLoad) begin
          rwQ <= rwNext;
          roQ <= roNext;
        end
      end

      assign rwData = rwQ;
      assign roData = roQ;
    end else begin : g_combOut
      logic unusedCtrlBits;
      assign unusedCtrlBits = ctrl.outClear ^ ctrl.outLoad;
      assign rwData = rwComb;
      assign roData = roComb;
    end
  endgenerate

endmodule

// File: rtl/dual_read_ram.sv
module dual_read_ram
  import dual_read_ram_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rwAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] roAddr,
  output logic [DATA_W-1:0] rwData,
  output logic [DATA_W-1:0] roData
);

  ramCtrl_t ctrl;

  dual_read_ram_ctrl u_ctrl (
    .rstN (rstN),
    .wrEn (wrEn),
    .ctrl (ctrl)
  );

  dual_read_ram_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REG_OUT (REG_OUT)
  ) u_datapath (
    .clk    (clk),
    .ctrl   (ctrl),
    .rwAddr (rwAddr),
    .wrData (wrData),
    .roAddr (roAddr),
    .rwData (rwData),
    .roData (roData)
  );

endmodule

// File: rtl/dual_read_ram_chk.sv
module dual_read_ram_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter bit REG_OUT = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] rwAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] roAddr,
  input logic [DATA_W-1:0] rwData,
  input logic [DATA_W-1:0] roData
);

  generate
    if (REG_OUT) begin : g_regChecks
      assert_reg_write_first_R7: assert property (@(posedge clk) disable iff (!rstN)
        wrEn |=> rwData == $past(wrData));

      assert_reg_ro_collision_R6: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && roAddr == rwAddr) |=> roData == $past(wrData));

      assert_reg_clear_R8: assert property (@(posedge clk)
        !rstN |=> (rwData == '0 && roData == '0));
    end else begin : g_combChecks
      assert_write_visible_R1: assert property (@(posedge clk) disable iff (!rstN)
        wrEn |=> (!$stable(rwAddr) || rwData == $past(wrData)));

      assert_ro_collision_R6: assert property (@(posedge clk) disable iff (!rstN)
        wrEn |=> (roAddr != $past(rwAddr) || roData == $past(wrData)));

      assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
        !wrEn |=> (!$stable(rwAddr) || $stable(rwData)));

      assert_ro_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && roAddr != rwAddr) |=> (!$stable(roAddr) || $stable(roData)));
    end
  endgenerate

endmodule

bind dual_read_ram dual_read_ram_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rwAddr (rwAddr),
  .wrData (wrData),
  .roAddr (roAddr),
  .rwData (rwData),
  .roData (roData)
);

// File: tb/dual_read_ram_bench.sv
`timescale 1ns/1ps
module dual_read_ram_bench;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] rwAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] roAddr = '0;
  logic [DW-1:0] combRw, combRo, regRw, regRo;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] refMem [DEPTH];
  bit            valid [DEPTH];

  always #2.5 clk = ~clk;

  dual_read_ram #(.DATA_W(DW), .ADDR_W(AW), .REG_OUT(1'b0)) u_dual_read_ram (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rwAddr(rwAddr), .wrData(wrData),
    .roAddr(roAddr), .rwData(combRw), .roData(combRo));

  dual_read_ram #(.DATA_W(DW), .ADDR_W(AW), .REG_OUT(1'b1)) u_dual_read_ram_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rwAddr(rwAddr), .wrData(wrData),
    .roAddr(roAddr), .rwData(regRw), .roData(regRo));

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return DW'(a * 37 + p * 11 + 5);
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check before and after the rising edge
  task automatic step(input logic we, input int a, input logic [DW-1:0] d,
                      input int ra, input string wTag);
    logic [DW-1:0] expRegRw, expRegRo;
    bit regRwOk, regRoOk;
    @(negedge clk);
    wrEn = we; rwAddr = AW'(a); wrData = d; roAddr = AW'(ra);
    #1;
    if (valid[a])  check(combRw, refMem[a],  "R3 comb shared read");
    if (valid[ra]) check(combRo, refMem[ra], "R4 comb read-only read");
    expRegRw = we ? d : refMem[a];
    regRwOk  = we || valid[a];
    expRegRo = (we && ra == a) ? d : refMem[ra];
    regRoOk  = (we && ra == a) || valid[ra];
    @(posedge clk);
    if (we) begin refMem[a] = d; valid[a] = 1'b1; end
    #1;
    if (valid[a])  check(combRw, refMem[a], wTag);
    if (valid[ra]) check(combRo, refMem[ra], (we && ra == a) ? "R6 collision ro" : "R5 ro isolated");
    if (regRwOk) check(regRw, expRegRw, "R7 registered shared");
    if (regRoOk) check(regRo, expRegRo, "R7 registered read-only");
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) valid[i] = 1'b0;
    // R8: registered outputs cleared under reset
    repeat (3) @(posedge clk);
    #1;
    check(regRw, '0, "R8 reset shared");
    check(regRo, '0, "R8 reset read-only");
    @(negedge clk); rstN = 1'b1;

    // Fill every location, read-only port trailing by one address
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, a, pat(a, 1), (a + DEPTH - 1) % DEPTH, "R1 write stored");

    // R2/R3/R4: all address pairs, enable low, data toggling
    for (int a = 0; a < DEPTH; a++)
      for (int ra = 0; ra < DEPTH; ra++)
        step(1'b0, a, ~pat(a, 9), ra, "R2 idle edge holds");

    // R5/R6: write with read-only port at every address
    for (int a = 0; a < DEPTH; a++)
      for (int ra = 0; ra < DEPTH; ra++)
        step(1'b1, a, pat(a, ra + 2), ra, "R6 write-first shared");

    // R8: reset does not disturb contents
    @(negedge clk); rstN = 1'b0; wrEn = 1'b0;
    @(posedge clk); #1;
    check(regRw, '0, "R8 reset clears regs");
    @(negedge clk); rstN = 1'b1;
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, a, '0, DEPTH - 1 - a, "R8 contents kept");

    report();
  end

endmodule